// File: doc/BRIEF.md
# First-Order Delta-Sigma Pulse-Density DAC

This block is a single-bit, first-order delta-sigma modulator. It takes an unsigned input word whose width is a parameter and produces one output bit per clock. Averaged over time, the fraction of clocks on which that bit is high is proportional to the input value. The output drives an I/O pin that feeds an external RC low-pass filter, and the filter recovers the analog level. A code of zero gives a steady low output. An all-ones code gives an output that is high on every clock except a small fraction.

Each clock, the modulator subtracts the binary weight of its present output from the input. This difference is the delta. It adds the delta to an accumulator, and the sum is the sigma. The accumulator is two bits wider than the input. Its most significant bit is the feedback and also the next output. When that bit is set, the feedback word equals full scale, so the accumulator falls. When the bit is clear, the feedback word is zero, so the accumulator rises by the input code. The output bit is a flop, so the pin toggles only at clock edges. The input may change on any cycle. The accumulator is not reset when it does.

Top module: `ds_dac`

## Requirements
- R1: While reset is high and on the first clock after it, `dac_out` is 0. Reset loads the accumulator with 2^W, which is bit W alone. With an all-ones input held from reset, the output is therefore low after the first clock edge following reset and high after the second.
- R2: With `din` equal to 0, `dac_out` never goes high.
- R3: With `din` all ones, the output is high on 2^W-1 or 2^W-2 clocks of every 2^W-clock window. It is never high on a full window.
- R4: For any input value v held steady, the number of high output clocks in any window of 2^W consecutive clocks lies within v-1 to v+1.
- R5: A new input value is used from the next clock edge, and the accumulator is not restarted. A window of 2^W clocks that begins right after the change already meets R4 for the new value. After a step from all ones to zero, the output is low within two clocks and stays low.
- R6: In steady state, the high pulses are spread out. For an input at or below half scale (2^(W-1)), no two consecutive output clocks are high. For an input at or above half scale, no two consecutive output clocks are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | W | Unsigned input code, 0 gives the lowest level |
| dac_out | output | 1 | Registered pulse-density output bit |

## Verification
The bench first checks the two clocks that follow reset with an all-ones input. An accumulator that resets to zero, or an output that is not registered, would put the first high pulse on the wrong clock. It runs the two end codes. A sign or width error in the feedback would let a zero code leak pulses, or would leave an all-ones code stuck high for a whole window. Mid-scale, near-half and random codes are checked for density within one count, and for pulse spreading on each side of half scale. An accumulator that is too narrow, or a wrong feedback weight, would show as a density error or as doubled pulses. Input steps are also checked. A design that latched the input late, or that cleared the accumulator on a change, would give a window that misses the new density, or a slow drop to zero.

// File: rtl/ds_dac.sv
module ds_dac #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic         dac_out
);
  localparam int SW = W + 2;
  localparam logic [SW-1:0] SIGMA_INIT = {2'b01, {W{1'b0}}};

  logic [SW-1:0] sigma_q;
  logic [SW-1:0] fb_word;
  logic [SW-1:0] delta;
  logic [SW-1:0] sigma_d;

  assign fb_word = {{2{sigma_q[SW-1]}}, {W{1'b0}}};
  assign delta   = {2'b00, din} + fb_word;
  assign sigma_d = delta + sigma_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sigma_q <= SIGMA_INIT;
      dac_out <= 1'b0;
    end else begin
      sigma_q <= sigma_d;
      dac_out <= sigma_d[SW-1];
    end
  end
endmodule

// File: rtl/ds_dac_chk.sv
module ds_dac_chk #(
  parameter int W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic [W-1:0]   din,
  input logic           dac_out,
  input logic [W+1:0]   sigma_q
);
  localparam int SW = W + 2;
  localparam logic [SW-1:0] LO_BOUND = {2'b01, {W{1'b0}}};
  localparam logic [SW-1:0] HI_BOUND = {2'b11, {W{1'b0}}};

  logic rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q === 1'b1) begin
      assert_reset_state_R1: assert (dac_out == 1'b0 && sigma_q == LO_BOUND)
        else $error("reset state wrong");
    end
  end

  assert_zero_stays_low_R2: assert property (@(posedge clk) disable iff (rst)
    (!dac_out && din == '0) |=> !dac_out);

  assert_acc_in_range_R4: assert property (@(posedge clk) disable iff (rst)
    (sigma_q >= LO_BOUND && sigma_q < HI_BOUND));

  assert_high_pulls_down_R4: assert property (@(posedge clk) disable iff (rst)
    dac_out |=> (sigma_q < $past(sigma_q)));

  assert_low_pushes_up_R4: assert property (@(posedge clk) disable iff (rst)
    !dac_out |=> (sigma_q >= $past(sigma_q)));

  assert_zero_no_double_R6: assert property (@(posedge clk) disable iff (rst)
    (dac_out && din == '0) |=> !dac_out);
endmodule

bind ds_dac ds_dac_chk #(.W(W)) u_chk (
  .clk(clk),
  .rst(rst),
  .din(din),
  .dac_out(dac_out),
  .sigma_q(sigma_q)
);

// File: tb/sim_ds_dac.sv
module sim_ds_dac;
  localparam int W    = 8;
  localparam int FULL = 1 << W;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic         dac_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  ds_dac #(.W(W)) u0 (.clk(clk), .rst(rst), .din(din), .dac_out(dac_out));

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input int v);
    din = v[W-1:0];
    rst = 1'b1;
    repeat (3) tick();
    rst = 1'b0;
  endtask

  task automatic window(output int highs, output int max_hi_run, output int max_lo_run);
    int hr = 0;
    int lr = 0;
    highs = 0; max_hi_run = 0; max_lo_run = 0;
    for (int i = 0; i < FULL; i++) begin
      tick();
      if (dac_out) begin
        highs++; hr++; lr = 0;
        if (hr > max_hi_run) max_hi_run = hr;
      end else begin
        lr++; hr = 0;
        if (lr > max_lo_run) max_lo_run = lr;
      end
    end
  endtask

  task automatic t_reset();
    din = '1;
    rst = 1'b1;
    repeat (3) tick();
    chk(dac_out == 1'b0, "R1 out during reset", dac_out, 0);
    rst = 1'b0;
    tick();
    chk(dac_out == 1'b0, "R1 first edge after reset", dac_out, 0);
    tick();
    chk(dac_out == 1'b1, "R1 second edge after reset", dac_out, 1);
  endtask

  task automatic t_zero();
    int h, mh, ml;
    do_reset(0);
    window(h, mh, ml);
    chk(h == 0, "R2 zero code window 1", h, 0);
    window(h, mh, ml);
    chk(h == 0, "R2 zero code window 2", h, 0);
  endtask

  task automatic t_ones();
    int h, mh, ml;
    do_reset(FULL - 1);
    window(h, mh, ml);
    window(h, mh, ml);
    chk(h >= FULL - 2 && h <= FULL - 1, "R3 all-ones density", h, FULL - 1);
    chk(mh < FULL, "R3 all-ones not stuck high", mh, FULL - 1);
  endtask

  task automatic t_level(input int v);
    int h, mh, ml;
    din = v[W-1:0];
    window(h, mh, ml);
    chk(h >= v - 1 && h <= v + 1, "R4 density first window", h, v);
    window(h, mh, ml);
    chk(h >= v - 1 && h <= v + 1, "R4 density steady window", h, v);
    if (v <= HALF && v > 0)
      chk(mh <= 1, "R6 no back-to-back highs", mh, 1);
    if (v >= HALF)
      chk(ml <= 1, "R6 no back-to-back lows", ml, 1);
  endtask

  task automatic t_switch();
    int h, mh, ml;
    do_reset(0);
    repeat (5) tick();
    din = '1;
    tick();
    chk(dac_out == 1'b0, "R5 first edge after step up", dac_out, 0);
    tick();
    chk(dac_out == 1'b1, "R5 step up used from next edge", dac_out, 1);
    din = 8'd200;
    window(h, mh, ml);
    din = 8'd50;
    window(h, mh, ml);
    chk(h >= 49 && h <= 51, "R5 window right after step down", h, 50);
    din = '1;
    window(h, mh, ml);
    din = '0;
    tick();
    tick();
    window(h, mh, ml);
    chk(h == 0, "R5 low soon after step to zero", h, 0);
  endtask

  initial begin
    t_reset();
    t_zero();
    t_ones();
    do_reset(0);
    t_level(1);
    t_level(64);
    t_level(HALF);
    t_level(HALF + 1);
    t_level(200);
    t_level(37);
    t_level(FULL - 1);
    for (int k = 0; k < 6; k++) t_level(int'($urandom_range(0, FULL - 1)));
    t_switch();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule